// File: doc/BRIEF.md
# Programmable Multi-Mode Bit Shifter

This block is the shift datapath of an arithmetic coprocessor. It holds a 32-bit operand register and a one-bit shift carry. A start pulse shifts the operand by a programmed number of positions, from 0 to 31, and the result replaces the operand in place. Three control bits are sampled at start. The first picks the direction. The second lets bits that leave one end come back in at the other end. The third brings the carry bit into the operation.

The engine moves one position per clock. A busy flag stays high until the last position is done. The operand and carry are loaded through simple write strobes while the engine is idle. Their current values are always visible on the outputs. The block has no port to the coprocessor's accumulator, so a shift cannot change it.

Top module: `shc_shifter`

## Requirements
- R1: A start accepted while idle with count N (5-bit field, 1..31) raises busy on the next clock. Busy stays high for exactly N cycles, one position per cycle, and the result is on the outputs when busy falls.
- R2: A start with count 0 never raises busy and leaves both the operand and the carry unchanged.
- R3: With circular=0 and carry-enable=0, vacated positions fill with zeros and the carry is unchanged.
- R4: With circular=1 and carry-enable=0, the operand rotates as a 32-bit ring and the carry is unchanged.
- R5: With circular=1 and carry-enable=1, the operand and carry rotate as a 33-bit ring. Each step, the carry enters the vacated end and the bit that leaves becomes the new carry.
- R6: With circular=0 and carry-enable=1, every vacated position takes the carry value held at start. The carry ends equal to the last bit shifted out.
- R7: Direction 1 moves bits toward the most significant end (bit 31 leaves). Direction 0 moves bits toward the least significant end (bit 0 leaves).
- R8: While busy, a further start, an operand write and a carry write are all ignored. A write issued in the same cycle as an accepted start is also ignored.
- R9: After reset the operand is 0, the carry is 0 and busy is 0.
- R10: While idle, an operand write loads a_wdata and a carry write loads c_wdata on the next clock. Without writes or a start, both hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_we | input | 1 | Operand write strobe |
| a_wdata | input | 32 | Operand write data |
| c_we | input | 1 | Carry write strobe |
| c_wdata | input | 1 | Carry write data |
| start | input | 1 | Start a shift |
| count | input | 5 | Number of positions to shift |
| dir_left | input | 1 | 1: toward MSB, 0: toward LSB |
| circ_en | input | 1 | Wrap-around enable |
| carry_en | input | 1 | Carry participation enable |
| a_q | output | 32 | Current operand/result |
| c_q | output | 1 | Current shift carry |
| busy | output | 1 | Shift in progress |

## Verification
The bench runs random operands and carries through all four mode combinations in both directions, using counts across the whole 0..31 range. Zero fill, the 32-bit rotate and the 33-bit ring produce different results for the same operand. The carry-fill mode differs from the ring as soon as more than one position is shifted, so any mixing of modes shows up. Directed cases cover count 0, count 1 and count 31, a lone MSB or LSB with a set carry, and start or write pulses during busy. Busy length is measured against the count in every run.

// File: rtl/shc_pkg.sv
// Package: shared types for the shifter.
// Assumes: mode is decoded from the circular and carry-enable bits at start.
package shc_pkg;
    typedef enum logic [1:0] {
        M_FILL0 = 2'b00,   // no wrap, no carry
        M_FILLC = 2'b01,   // carry fills, carry catches the outgoing bit
        M_ROT   = 2'b10,   // 32-bit rotate
        M_RING  = 2'b11    // 33-bit rotate through carry
    } mode_e;

    typedef struct packed {
        logic  left;
        mode_e mode;
    } ctrl_t;

    function automatic mode_e decode_mode(input logic circ, input logic cen);
        return mode_e'({circ, cen});
    endfunction
endpackage

// File: rtl/shc_seq.sv
// Module: position counter and busy flag.
// Assumes: start is honoured only while idle; count 0 is done at once.
module shc_seq #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             accept,
    output logic             busy
);
    logic [CNT_W-1:0] remain_q;

    // Purpose: a start is taken only when no shift is running.
    always_comb accept = start && !busy;

    // Purpose: load the remaining count and step it down once per position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            busy     <= 1'b0;
        end else if (accept) begin
            remain_q <= count;
            busy     <= (count != '0);
        end else if (busy) begin
            remain_q <= remain_q - 1'b1;
            busy     <= (remain_q != CNT_W'(1));
        end
    end
endmodule

// File: rtl/shc_step.sv
// Module: one-position shift of operand and carry.
// Assumes: purely combinational; the caller registers the outputs.
module shc_step
    import shc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic              c_in,
    input  logic              fill_c,
    input  ctrl_t             ctrl,
    output logic [DATA_W-1:0] a_out,
    output logic              c_out
);
    logic out_bit;
    logic in_bit;

    // Purpose: pick the bit that leaves, from the end the shift moves toward.
    always_comb out_bit = ctrl.left ? a_in[DATA_W-1] : a_in[0];

    // Purpose: pick the bit that enters the vacated end, and the next carry.
    always_comb begin
        unique case (ctrl.mode)
            M_FILL0: begin in_bit = 1'b0;    c_out = c_in;    end
            M_ROT:   begin in_bit = out_bit; c_out = c_in;    end
            M_RING:  begin in_bit = c_in;    c_out = out_bit; end
            M_FILLC: begin in_bit = fill_c;  c_out = out_bit; end
            default: begin in_bit = 1'b0;    c_out = c_in;    end
        endcase
    end

    // Purpose: put the shifted operand together.
    always_comb begin
        if (ctrl.left) a_out = {a_in[DATA_W-2:0], in_bit};
        else           a_out = {in_bit, a_in[DATA_W-1:1]};
    end
endmodule

// File: rtl/shc_shifter.sv
// Module: top of the shift engine; holds the operand and carry registers.
// Assumes: writes are taken only while idle and with no start in that cycle;
// the control bits are latched when a start is accepted.
module shc_shifter
    import shc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              c_we,
    input  logic              c_wdata,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic              dir_left,
    input  logic              circ_en,
    input  logic              carry_en,
    output logic [DATA_W-1:0] a_q,
    output logic              c_q,
    output logic              busy
);
    ctrl_t             ctrl_q;
    logic              fill_q;
    logic              accept;
    logic [DATA_W-1:0] a_nxt;
    logic              c_nxt;
    logic              wr_ok;

    shc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .count  (count),
        .accept (accept),
        .busy   (busy)
    );

    shc_step #(.DATA_W(DATA_W)) u_step (
        .a_in   (a_q),
        .c_in   (c_q),
        .fill_c (fill_q),
        .ctrl   (ctrl_q),
        .a_out  (a_nxt),
        .c_out  (c_nxt)
    );

    // Purpose: writes land only in an idle cycle that takes no start.
    always_comb wr_ok = !busy && !start;

    // Purpose: latch the controls and the fill carry when a shift is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{left: 1'b0, mode: M_FILL0};
            fill_q <= 1'b0;
        end else if (accept) begin
            ctrl_q <= '{left: dir_left, mode: decode_mode(circ_en, carry_en)};
            fill_q <= c_q;
        end
    end

    // Purpose: the operand register takes a write or a shift step.
    always_ff @(posedge clk) begin
        if (!rst_n)             a_q <= '0;
        else if (busy)          a_q <= a_nxt;
        else if (wr_ok && a_we) a_q <= a_wdata;
    end

    // Purpose: the carry register takes a write or a shift step.
    always_ff @(posedge clk) begin
        if (!rst_n)             c_q <= 1'b0;
        else if (busy)          c_q <= c_nxt;
        else if (wr_ok && c_we) c_q <= c_wdata;
    end
endmodule

// File: rtl/shc_shifter_chk.sv
// Module: assertion checker bound to shc_shifter.
// Assumes: sees the top ports plus its latched control.
module shc_shifter_chk
    import shc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_we,
    input logic              c_we,
    input logic              start,
    input logic [CNT_W-1:0]  count,
    input logic [DATA_W-1:0] a_q,
    input logic              c_q,
    input logic              busy,
    input ctrl_t             ctrl_q
);
    logic [CNT_W:0] run_q;

    // Purpose: measure how long the current busy run has lasted.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    a_r1_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count != '0) |=> busy);

    a_r1_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CNT_W+1)'((1 << CNT_W) - 1));

    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count == '0) |=> (!busy && $stable(a_q) && $stable(c_q)));

    a_r3_zero_fill_left: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_q.mode == M_FILL0 && ctrl_q.left) |=> (a_q == {$past(a_q[DATA_W-2:0]), 1'b0}));

    a_r4_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ctrl_q.mode == M_FILL0 || ctrl_q.mode == M_ROT)) |=> $stable(c_q));

    a_r5_ring_right: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_q.mode == M_RING && !ctrl_q.left) |=> (c_q == $past(a_q[0])));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !a_we && !c_we) |=> ($stable(a_q) && $stable(c_q)));
endmodule

bind shc_shifter shc_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_we   (a_we),
    .c_we   (c_we),
    .start  (start),
    .count  (count),
    .a_q    (a_q),
    .c_q    (c_q),
    .busy   (busy),
    .ctrl_q (ctrl_q)
);

// File: tb/shc_shifter_tb.sv
module shc_shifter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_we = 1'b0;
    logic [31:0] a_wdata = '0;
    logic        c_we = 1'b0;
    logic        c_wdata = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  count = '0;
    logic        dir_left = 1'b0;
    logic        circ_en = 1'b0;
    logic        carry_en = 1'b0;
    logic [31:0] a_q;
    logic        c_q;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    shc_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .a_we(a_we), .a_wdata(a_wdata),
        .c_we(c_we), .c_wdata(c_wdata), .start(start), .count(count),
        .dir_left(dir_left), .circ_en(circ_en), .carry_en(carry_en),
        .a_q(a_q), .c_q(c_q), .busy(busy)
    );

    // Reference: {carry, operand} after n steps, written from the requirements.
    function automatic logic [32:0] ref_shift(input logic [31:0] a, input logic c,
            input int n, input logic left, input logic circ, input logic cen);
        logic fill = c;
        for (int i = 0; i < n; i++) begin
            logic ob = left ? a[31] : a[0];
            logic ib;
            if (!circ && !cen)     ib = 1'b0;
            else if (circ && !cen) ib = ob;
            else if (circ && cen)  ib = c;
            else                   ib = fill;
            if (cen) c = ob;
            a = left ? {a[30:0], ib} : {ib, a[31:1]};
        end
        return {c, a};
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] a, input logic c);
        @(negedge clk);
        a_we = 1'b1; a_wdata = a; c_we = 1'b1; c_wdata = c;
        @(negedge clk);
        a_we = 1'b0; c_we = 1'b0;
    endtask

    // Run one shift, measure busy length, compare result with the reference.
    task automatic run(input string req, input logic [31:0] a, input logic c, input int n,
            input logic left, input logic circ, input logic cen);
        int blen = 0;
        logic [32:0] exp = ref_shift(a, c, n, left, circ, cen);
        load(a, c);
        check("R10", {c_q, a_q}, {c, a});
        start = 1'b1; count = 5'(n); dir_left = left; circ_en = circ; carry_en = cen;
        @(negedge clk);
        start = 1'b0;
        while (busy && blen < 40) begin
            blen++;
            @(negedge clk);
        end
        check("R1", 33'(blen), 33'(n));
        check(req, {c_q, a_q}, exp);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R9", {busy, c_q, a_q[31:1]}, '0);
        check("R9", 33'(a_q[0]), '0);
        rst_n = 1'b1;

        // Directed corners
        run("R2", 32'hDEADBEEF, 1'b1, 0, 1'b1, 1'b1, 1'b1);
        run("R3", 32'h8000_0001, 1'b1, 1, 1'b1, 1'b0, 1'b0);
        run("R3", 32'hFFFF_FFFF, 1'b1, 31, 1'b0, 1'b0, 1'b0);
        run("R4", 32'h8000_0001, 1'b0, 1, 1'b1, 1'b1, 1'b0);
        run("R4", 32'h1234_5678, 1'b1, 31, 1'b0, 1'b1, 1'b0);
        run("R5", 32'h8000_0000, 1'b1, 1, 1'b1, 1'b1, 1'b1);
        run("R5", 32'h0000_0001, 1'b0, 31, 1'b0, 1'b1, 1'b1);
        run("R6", 32'h0000_0000, 1'b1, 8, 1'b1, 1'b0, 1'b1);
        run("R6", 32'hF000_000F, 1'b0, 5, 1'b0, 1'b0, 1'b1);
        run("R7", 32'h0000_0001, 1'b0, 4, 1'b1, 1'b0, 1'b0);
        check("R7", {c_q, a_q}, {1'b0, 32'h0000_0010});
        run("R7", 32'h0000_0010, 1'b0, 4, 1'b0, 1'b0, 1'b0);
        check("R7", {c_q, a_q}, {1'b0, 32'h0000_0001});

        // R8: start and writes during busy are ignored
        begin
            logic [32:0] exp = ref_shift(32'hA5A5_0F0F, 1'b1, 10, 1'b1, 1'b1, 1'b1);
            load(32'hA5A5_0F0F, 1'b1);
            start = 1'b1; count = 5'd10; dir_left = 1'b1; circ_en = 1'b1; carry_en = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            start = 1'b1; count = 5'd3; dir_left = 1'b0; circ_en = 1'b0; carry_en = 1'b0;
            a_we = 1'b1; a_wdata = 32'h0; c_we = 1'b1; c_wdata = 1'b0;
            @(negedge clk);
            start = 1'b0; a_we = 1'b0; c_we = 1'b0;
            repeat (12) @(negedge clk);
            check("R8", {busy, 32'h0}, {1'b0, 32'h0});
            check("R8", {c_q, a_q}, exp);
        end
        // R8: write in the same cycle as an accepted start is dropped
        load(32'h0000_00FF, 1'b0);
        @(negedge clk);
        start = 1'b1; count = 5'd0; a_we = 1'b1; a_wdata = 32'h1111_1111;
        @(negedge clk);
        start = 1'b0; a_we = 1'b0;
        check("R8", {c_q, a_q}, {1'b0, 32'h0000_00FF});
        // R10: idle hold
        repeat (4) @(negedge clk);
        check("R10", {c_q, a_q}, {1'b0, 32'h0000_00FF});

        // Random trials over every mode
        for (int t = 0; t < 60; t++) begin
            logic [2:0] m = 3'($urandom());
            string req;
            case ({m[1], m[2]})
                2'b00: req = "R3";
                2'b10: req = "R4";
                2'b11: req = "R5";
                default: req = "R6";
            endcase
            run(req, $urandom(), 1'($urandom()), int'($urandom() % 32), m[0], m[1], m[2]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule